// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This block watches the data memory accesses of a processor core and reports when one of them touches a programmed address with a programmed access type. It holds two 32-bit watch addresses and a small control word, all reached through a plain register port with a 2-bit select. The core presents one access descriptor per cycle: a valid flag, the byte address, a size code, an aligned flag and an access kind. The unit answers one cycle later with a hit flag for each watch address and a combined hit.

The second watch address can serve either as an independent watchpoint or as a bit mask over the first one. As a mask, it widens the first watchpoint into a range of addresses. A multi-byte access is caught when any byte it covers matches. Swaps are classed as writes. Prefetch hints and cache maintenance operations never raise a hit.

Top module: `dbrk_unit`

## Requirements
- R1: After reset, the control word and both watch addresses read as zero, and all hit outputs are low.
- R2: Select 0 reads and writes watch address A, and select 1 reads and writes watch address B, each as a full 32-bit value. Select 2 reads and writes the control word. Select 3 reads as zero, and writes to it change nothing.
- R3: In the control word, bit 8 is the B mode bit, bits 3:2 are the B type field and bits 1:0 are the A type field. Every other bit reads as zero and ignores writes.
- R4: A type field decodes as follows: 00 is off, 01 is writes only, 10 is reads or writes, and 11 is reads only.
- R5: A hit needs any byte covered by the access to equal the watch address. The size code gives the bytes covered: 0 is 1 byte, 1 is 2 bytes, 2 and 3 are 4 bytes. The bytes run upward from the start address.
- R6: When the aligned flag is low, the start address is rounded down to a multiple of 4 before the bytes are formed.
- R7: Kind 2 (swap) counts as a write. It hits a writes-only or a reads-or-writes watchpoint, and never hits a reads-only one. Kind 0 is a read and kind 1 is a write.
- R8: Kind 3 (prefetch hint), kind 4 (cache or translation maintenance) and kinds 5 to 7 never cause a hit.
- R9: With the mode bit at 1, every bit set in address B is excluded from the comparison against address A. In this mode the B type field has no effect and hit B stays low.
- R10: A hit on A, including a masked range hit, requires the A type field to be non-zero.
- R11: With the mode bit at 0, address B is an independent watchpoint controlled only by the B type field.
- R12: Each hit output is registered. It is high in the cycle after a valid matching access and low after any cycle with valid low. The combined hit is the OR of hit A and hit B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 addr A, 1 addr B, 2 control, 3 none |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel (combinational) |
| acc_valid | input | 1 | Access descriptor valid |
| acc_addr | input | 32 | Access byte address |
| acc_size | input | 2 | Size code: 0 one byte, 1 two bytes, 2 or 3 four bytes |
| acc_aligned | input | 1 | High when acc_addr is naturally aligned |
| acc_kind | input | 3 | 0 read, 1 write, 2 swap, 3 prefetch, 4 cache op, 5-7 other |
| hit_a | output | 1 | Registered hit on watch address A |
| hit_b | output | 1 | Registered hit on watch address B |
| hit_any | output | 1 | OR of hit_a and hit_b |

## Verification
The hardest situation to reach from the ports is a masked range hit in which an access matches address A only because of the bits that address B masks out. The B type field must also be set to a value that would otherwise fire hit B. Plain random addresses across 32 bits almost never land there. The random phase therefore draws the watch addresses, the mask and the access addresses from a window of a few dozen bytes, and it draws all control bits freely. Directed cases also build this situation, and the unaligned-rounding and swap-against-reads-only cases, explicitly.

// File: rtl/dbrk_pkg.sv
// Package: shared encodings for the data watchpoint unit.
// Assumes: access kind codes and type field codes fixed as in the brief.
package dbrk_pkg;

    typedef enum logic [2:0] {
        KIND_READ   = 3'd0,
        KIND_WRITE  = 3'd1,
        KIND_SWAP   = 3'd2,
        KIND_PREF   = 3'd3,
        KIND_CACHE  = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        WT_OFF   = 2'b00,
        WT_WRITE = 2'b01,
        WT_BOTH  = 2'b10,
        WT_READ  = 2'b11
    } watch_type_e;

    // Control word bit positions.
    localparam int unsigned CTL_MODE_BIT = 8;
    localparam int unsigned CTL_B_LSB    = 2;
    localparam int unsigned CTL_A_LSB    = 0;

    // True when an access kind qualifies under a given type field.
    function automatic logic kind_qualifies(input logic [1:0] wtype, input logic [2:0] kind);
        logic is_rd;
        logic is_wr;
        is_rd = (kind == KIND_READ);
        is_wr = (kind == KIND_WRITE) || (kind == KIND_SWAP);
        case (wtype)
            WT_WRITE: kind_qualifies = is_wr;
            WT_BOTH:  kind_qualifies = is_rd || is_wr;
            WT_READ:  kind_qualifies = is_rd;
            default:  kind_qualifies = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dbrk_regs.sv
// Module: dbrk_regs
// Holds the two watch addresses and the control fields behind a
// select-addressed register port. Reads are combinational.
// Assumes: one write per cycle, select 3 is an empty slot.
module dbrk_regs
    import dbrk_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr_a,
    output logic [ADDR_W-1:0] addr_b,
    output logic              mode_mask,
    output logic [1:0]        type_a,
    output logic [1:0]        type_b
);

    localparam logic [1:0] SEL_A   = 2'd0;
    localparam logic [1:0] SEL_B   = 2'd1;
    localparam logic [1:0] SEL_CTL = 2'd2;

    // Register storage update on writes; all cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_a    <= '0;
            addr_b    <= '0;
            mode_mask <= 1'b0;
            type_a    <= WT_OFF;
            type_b    <= WT_OFF;
        end else if (wr_en) begin
            case (sel)
                SEL_A:   addr_a <= wdata;
                SEL_B:   addr_b <= wdata;
                SEL_CTL: begin
                    mode_mask <= wdata[CTL_MODE_BIT];
                    type_b    <= wdata[CTL_B_LSB +: 2];
                    type_a    <= wdata[CTL_A_LSB +: 2];
                end
                default: ;
            endcase
        end
    end

    // Read mux; control word packs fields, reserved bits zero.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_A:   rdata = addr_a;
            SEL_B:   rdata = addr_b;
            SEL_CTL: begin
                rdata[CTL_MODE_BIT]     = mode_mask;
                rdata[CTL_B_LSB +: 2]   = type_b;
                rdata[CTL_A_LSB +: 2]   = type_a;
            end
            default: rdata = '0;
        endcase
    end

    // R1: the cycle reset is released, every stored field is still clear.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (addr_a == '0 && addr_b == '0 && !mode_mask &&
                          type_a == WT_OFF && type_b == WT_OFF));

    // R2: a write to the empty slot leaves every register unchanged.
    assert_empty_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 2'd3) |=> ($stable(addr_a) && $stable(addr_b) &&
                                    $stable(mode_mask) && $stable(type_a) && $stable(type_b)));

endmodule

// File: rtl/dbrk_match.sv
// Module: dbrk_match
// Combinational compare of one access against one watch address.
// Forms the covered byte addresses, applies the ignore mask and the
// access type filter. Assumes ACC_BYTES is a power of two.
module dbrk_match
    import dbrk_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned ACC_BYTES = 4
) (
    input  logic [ADDR_W-1:0] watch_addr,
    input  logic [ADDR_W-1:0] ignore_mask,
    input  logic [1:0]        wtype,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_aligned,
    input  logic [2:0]        acc_kind,
    output logic              match
);

    localparam int unsigned OFS_W = (ACC_BYTES > 1) ? $clog2(ACC_BYTES) : 1;
    localparam logic [ADDR_W-1:0] ROUND_MASK = ~ADDR_W'(ACC_BYTES - 1);

    logic [ADDR_W-1:0]    start_addr;
    logic [ACC_BYTES-1:0] lane_hit;

    // Start address, rounded down when the access is unaligned.
    always_comb begin
        start_addr = acc_aligned ? acc_addr : (acc_addr & ROUND_MASK);
    end

    // One comparator per byte lane the access may cover.
    for (genvar g = 0; g < ACC_BYTES; g++) begin : g_lane
        logic [ADDR_W-1:0] byte_addr;
        logic              lane_on;
        always_comb begin
            byte_addr = start_addr + ADDR_W'(g);
            lane_on   = ((32'(g) >> acc_size) == 32'd0);
            lane_hit[g] = lane_on &&
                          (((byte_addr ^ watch_addr) & ~ignore_mask) == '0);
        end
    end

    // Final match: some lane equal and the kind passes the type filter.
    always_comb begin
        match = (|lane_hit) && kind_qualifies(wtype, acc_kind);
    end

    // R8: prefetch and maintenance kinds never produce a match.
    always_comb begin
        assert_no_hint_match_R8: assert (!(match && acc_kind >= 3'd3));
    end

    // R4: an off type field never produces a match.
    always_comb begin
        assert_off_silent_R4: assert (!(match && wtype == WT_OFF));
    end

endmodule

// File: rtl/dbrk_unit.sv
// Module: dbrk_unit (top)
// Data watchpoint unit: register port plus two compare channels whose
// results are registered into hit flags. Channel A may use address B
// as an ignore mask; then channel B is forced off.
// Assumes: one access descriptor per cycle, synchronous active-low reset.
module dbrk_unit
    import dbrk_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned ACC_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_aligned,
    input  logic [2:0]        acc_kind,
    output logic              hit_a,
    output logic              hit_b,
    output logic              hit_any
);

    localparam int unsigned NCH = 2;

    logic [ADDR_W-1:0] addr_a, addr_b;
    logic              mode_mask;
    logic [1:0]        type_a, type_b;

    logic [ADDR_W-1:0] ch_addr [NCH];
    logic [ADDR_W-1:0] ch_mask [NCH];
    logic [1:0]        ch_type [NCH];
    logic [NCH-1:0]    ch_match;
    logic [NCH-1:0]    hit_q;

    dbrk_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .sel       (reg_sel),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .addr_a    (addr_a),
        .addr_b    (addr_b),
        .mode_mask (mode_mask),
        .type_a    (type_a),
        .type_b    (type_b)
    );

    // Channel setup: A takes B as mask in mask mode, B is silenced then.
    always_comb begin
        ch_addr[0] = addr_a;
        ch_mask[0] = mode_mask ? addr_b : '0;
        ch_type[0] = type_a;
        ch_addr[1] = addr_b;
        ch_mask[1] = '0;
        ch_type[1] = mode_mask ? WT_OFF : type_b;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dbrk_match #(.ADDR_W(ADDR_W), .ACC_BYTES(ACC_BYTES)) u_match (
            .watch_addr  (ch_addr[c]),
            .ignore_mask (ch_mask[c]),
            .wtype       (ch_type[c]),
            .acc_addr    (acc_addr),
            .acc_size    (acc_size),
            .acc_aligned (acc_aligned),
            .acc_kind    (acc_kind),
            .match       (ch_match[c])
        );
    end

    // Hit registers: capture matches of valid accesses only.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= '0;
        else        hit_q <= ch_match & {NCH{acc_valid}};
    end

    assign hit_a   = hit_q[0];
    assign hit_b   = hit_q[1];
    assign hit_any = |hit_q;

    // R12: a hit is only raised after a cycle with a valid access.
    assert_hit_needs_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> $past(acc_valid));

    // R9: in mask mode, address B never reports its own hit.
    assert_mask_mode_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b |-> !$past(mode_mask));

    // R10: a hit on A requires the A type field to be enabled.
    assert_a_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |-> ($past(type_a) != WT_OFF));

    // R7: a reads-only watch on A never fires for a write or swap.
    assert_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && $past(type_a) == WT_READ) |-> ($past(acc_kind) == KIND_READ));

    // R3: control word reserved bits always read as zero.
    always_comb begin
        assert_ctl_reserved_R3: assert (reg_sel != 2'd2 ||
                                        (reg_rdata & ~ADDR_W'(32'h0000_010F)) == '0);
    end

endmodule

// File: tb/sim_dbrk_unit.sv
module sim_dbrk_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = 2'd0;
    logic        acc_aligned = 1'b1;
    logic [2:0]  acc_kind = 3'd0;
    logic        hit_a, hit_b, hit_any;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] m_a, m_b, m_ctl;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbrk_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_aligned(acc_aligned),
        .acc_kind(acc_kind), .hit_a(hit_a), .hit_b(hit_b), .hit_any(hit_any)
    );

    function automatic bit type_ok(input logic [1:0] t, input logic [2:0] k);
        bit rd, wr;
        rd = (k == 3'd0);
        wr = (k == 3'd1) || (k == 3'd2);
        case (t)
            2'b01:   return wr;
            2'b10:   return rd || wr;
            2'b11:   return rd;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit any_byte(input logic [31:0] w, input logic [31:0] msk,
                                    input logic [31:0] ad, input logic [1:0] sz,
                                    input logic al);
        logic [31:0] st;
        int n;
        st = al ? ad : {ad[31:2], 2'b00};
        n  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        for (int i = 0; i < n; i++)
            if ((((st + 32'(i)) ^ w) & ~msk) == 32'd0) return 1'b1;
        return 1'b0;
    endfunction

    // Expected {hit_b, hit_a} for one valid access.
    function automatic logic [1:0] model(input logic [31:0] ad, input logic [1:0] sz,
                                         input logic al, input logic [2:0] k);
        logic ha, hb;
        logic [31:0] msk;
        msk = m_ctl[8] ? m_b : 32'd0;
        ha = type_ok(m_ctl[1:0], k) && any_byte(m_a, msk, ad, sz, al);
        hb = !m_ctl[8] && type_ok(m_ctl[3:2], k) && any_byte(m_b, 32'd0, ad, sz, al);
        return {hb, ha};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (s == 2'd0) m_a = d;
        else if (s == 2'd1) m_b = d;
        else if (s == 2'd2) m_ctl = d & 32'h0000_010F;
    endtask

    task automatic rd_check(input string req, input logic [1:0] s, input logic [31:0] exp);
        reg_sel = s;
        #1;
        check(req, reg_rdata, exp);
    endtask

    // Drive one access at a falling edge, check hits at the next falling edge.
    task automatic acc(input string req, input logic v, input logic [31:0] ad,
                       input logic [1:0] sz, input logic al, input logic [2:0] k);
        logic [1:0] e;
        @(negedge clk);
        acc_valid = v; acc_addr = ad; acc_size = sz; acc_aligned = al; acc_kind = k;
        e = v ? model(ad, sz, al, k) : 2'b00;
        @(negedge clk);
        acc_valid = 1'b0;
        check(req, {29'd0, hit_any, hit_b, hit_a}, {29'd0, |e, e[1], e[0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_a = '0; m_b = '0; m_ctl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd_check("R1 addrA", 2'd0, 32'd0);
        rd_check("R1 addrB", 2'd1, 32'd0);
        rd_check("R1 ctl",   2'd2, 32'd0);
        check("R1 hits", {29'd0, hit_any, hit_b, hit_a}, 32'd0);

        // R2/R3: register access, reserved bits, empty slot
        wr(2'd0, 32'hDEAD_BEEF);
        wr(2'd1, 32'h1234_5678);
        wr(2'd2, 32'hFFFF_FFFF);
        rd_check("R2 addrA rw", 2'd0, 32'hDEAD_BEEF);
        rd_check("R2 addrB rw", 2'd1, 32'h1234_5678);
        rd_check("R3 ctl reserved", 2'd2, 32'h0000_010F);
        wr(2'd3, 32'hFFFF_FFFF);
        rd_check("R2 slot3 reads zero", 2'd3, 32'd0);
        rd_check("R2 slot3 write no effect A", 2'd0, 32'hDEAD_BEEF);
        rd_check("R2 slot3 write no effect ctl", 2'd2, 32'h0000_010F);

        // R5: any byte of a word access; byte access outside misses
        wr(2'd0, 32'h0000_0103);
        wr(2'd1, 32'h0000_0200);
        wr(2'd2, 32'h0000_0002);
        acc("R5 word covers byte3", 1'b1, 32'h100, 2'd2, 1'b1, 3'd0);
        acc("R5 byte miss", 1'b1, 32'h102, 2'd0, 1'b1, 3'd0);
        acc("R5 half covers", 1'b1, 32'h102, 2'd1, 1'b1, 3'd1);
        acc("R12 invalid no hit", 1'b0, 32'h100, 2'd2, 1'b1, 3'd0);
        // R6: unaligned rounding down
        wr(2'd0, 32'h0000_0101);
        acc("R6 unaligned rounds down", 1'b1, 32'h103, 2'd1, 1'b0, 3'd0);
        acc("R6 aligned flag keeps addr", 1'b1, 32'h103, 2'd1, 1'b1, 3'd0);
        // R7/R4: swap vs reads-only and writes-only
        wr(2'd2, 32'h0000_0003);
        acc("R7 swap vs read-only", 1'b1, 32'h101, 2'd0, 1'b1, 3'd2);
        acc("R4 read vs read-only", 1'b1, 32'h101, 2'd0, 1'b1, 3'd0);
        wr(2'd2, 32'h0000_0001);
        acc("R7 swap vs write-only", 1'b1, 32'h101, 2'd0, 1'b1, 3'd2);
        acc("R4 read vs write-only", 1'b1, 32'h101, 2'd0, 1'b1, 3'd0);
        // R8: prefetch and cache op ignored
        wr(2'd2, 32'h0000_000A);
        acc("R8 prefetch", 1'b1, 32'h101, 2'd0, 1'b1, 3'd3);
        acc("R8 cache op", 1'b1, 32'h101, 2'd0, 1'b1, 3'd4);
        // R11: independent B
        acc("R11 B independent", 1'b1, 32'h200, 2'd0, 1'b1, 3'd1);
        // R9: mask mode range, B type ignored, no hit_b
        wr(2'd1, 32'h0000_00F0);
        wr(2'd2, 32'h0000_010A);
        acc("R9 masked range", 1'b1, 32'h1E1, 2'd0, 1'b1, 3'd0);
        acc("R9 unmasked bit differs", 1'b1, 32'h105, 2'd0, 1'b1, 3'd0);
        acc("R9 B addr no own hit", 1'b1, 32'h0F0, 2'd0, 1'b1, 3'd0);
        // R10: mask without A enable
        wr(2'd2, 32'h0000_010C);
        acc("R10 mask needs A enable", 1'b1, 32'h1E1, 2'd0, 1'b1, 3'd0);

        // Random phase in a narrow window
        for (int it = 0; it < 600; it++) begin
            if (it % 20 == 0) begin
                wr(2'd0, 32'h1000 + ($urandom % 32));
                wr(2'd1, (($urandom % 2) == 0) ? (32'h1000 + ($urandom % 32)) : ($urandom % 16));
                wr(2'd2, $urandom);
            end
            acc("R12 random", ($urandom % 4) != 0, 32'h1000 + ($urandom % 40),
                2'($urandom), 1'($urandom), 3'($urandom % 6));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule